// File: doc/BRIEF.md
# Virtualized Time CSR Unit

This unit answers control/status register accesses to the platform time counter and holds a 64-bit guest time offset for a core that supports virtualization. While virtualization is on, reads of the time register return the platform time plus the stored offset. Otherwise they return the platform time unchanged. Hypervisor software sets the offset so that a guest sees its own timeline, and no trap is taken.

The unit claims four register addresses: time (0xC01), timeh (0xC81), offset (0x605) and offset-high (0x615). The core's CSR decode depends on these values. A parameter selects a 32-bit register mode, in which every 64-bit quantity is reached as two halves, or a 64-bit mode. In 64-bit mode the high-half addresses do not exist. If the platform reports that it has no time source, every access is refused, so that firmware can trap the access and emulate it. Read data and the illegal flag are combinational in the cycle of the strobe. Writes take effect at the next rising clock edge.

Top module: `vtime_csr_unit`

## Requirements
- R1: A read of time (0xC01) returns the low XLEN bits of platform time plus the offset when virt_en is 1, and of platform time plus zero when virt_en is 0.
- R2: When time_src_present is 0, any access to 0xC01, 0xC81, 0x605 or 0x615 sets csr_illegal, and the offset is not changed.
- R3: In 32-bit mode, a read of timeh (0xC81) returns bits 63:32 of the full 64-bit sum, including the carry out of the low half.
- R4: In 32-bit mode, a write to 0x605 replaces only offset bits 31:0, and a write to 0x615 replaces only bits 63:32.
- R5: In 32-bit mode, a read of 0x605 returns offset bits 31:0, and a read of 0x615 returns bits 63:32.
- R6: In 64-bit mode, 0x605 reads and writes all 64 offset bits, and any access to 0xC81 or 0x615 is illegal.
- R7: The privilege encoding is U=0, S=1, M=3. Offset registers are legal only from S or M with virt_en 0. Time registers are readable from any level.
- R8: Writes to time or timeh are illegal and change no state.
- R9: The sum wraps modulo 2^64 and gives no overflow indication.
- R10: The offset resets to zero. Read data appears in the same cycle as csr_valid and is zero whenever csr_illegal is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | 64 | Platform time value |
| time_src_present | input | 1 | A platform time source exists |
| virt_en | input | 1 | Virtualization enabled |
| priv | input | 2 | Current privilege level |
| csr_valid | input | 1 | Access strobe |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, combinational |
| csr_illegal | output | 1 | Access refused |

## Verification
The bench builds two copies of the unit on shared stimulus: one with RV32=1 and one with RV32=0. The 32-bit copy brings half-register writes, half reads and the carry from the low to the high half within reach. The 64-bit copy covers the full-width offset, the wrap past 2^64 and the missing high-half addresses.

// File: rtl/vtime_pkg.sv
package vtime_pkg;
    localparam int TIME_W = 64;
    localparam int HALF_W = TIME_W / 2;

    localparam logic [11:0] ADDR_TIME   = 12'hC01;
    localparam logic [11:0] ADDR_TIMEH  = 12'hC81;
    localparam logic [11:0] ADDR_OFS    = 12'h605;
    localparam logic [11:0] ADDR_OFSH   = 12'h615;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_TIME,
        REG_TIMEH,
        REG_OFS,
        REG_OFSH
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     illegal;
        logic     wr_lo;
        logic     wr_hi;
    } dec_t;

    function automatic logic is_time_reg(reg_sel_e s);
        return (s == REG_TIME) || (s == REG_TIMEH);
    endfunction
endpackage

// File: rtl/vtime_decode.sv
module vtime_decode
    import vtime_pkg::*;
#(
    parameter bit RV32 = 1'b1
) (
    input  logic        valid,
    input  logic        we,
    input  logic [11:0] addr,
    input  logic [1:0]  priv,
    input  logic        virt_en,
    input  logic        src_present,
    output dec_t        dec
);
    reg_sel_e sel;
    logic     priv_ok;
    logic     refuse;

    always_comb begin
        unique case (addr)
            ADDR_TIME:  sel = REG_TIME;
            ADDR_TIMEH: sel = RV32 ? REG_TIMEH : REG_NONE;
            ADDR_OFS:   sel = REG_OFS;
            ADDR_OFSH:  sel = RV32 ? REG_OFSH : REG_NONE;
            default:    sel = REG_NONE;
        endcase
    end

    always_comb begin
        priv_ok = 1'b1;
        if (!is_time_reg(sel)) begin
            priv_ok = !virt_en &&
                      ((priv_e'(priv) == PRIV_S) || (priv_e'(priv) == PRIV_M));
        end
    end

    always_comb begin
        refuse = (sel == REG_NONE) || !src_present || !priv_ok ||
                 (we && is_time_reg(sel));
        dec.sel     = sel;
        dec.illegal = valid && refuse;
        dec.wr_lo   = valid && we && !refuse && (sel == REG_OFS);
        dec.wr_hi   = valid && we && !refuse &&
                      ((sel == REG_OFSH) || (!RV32 && sel == REG_OFS));
    end
endmodule

// File: rtl/vtime_offset_reg.sv
module vtime_offset_reg
    import vtime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] data_lo,
    input  logic [HALF_W-1:0] data_hi,
    output logic [TIME_W-1:0] offset_q
);
    logic [1:0]              wr;
    logic [1:0][HALF_W-1:0]  din;

    assign wr  = {wr_hi, wr_lo};
    assign din = {data_hi, data_lo};

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                offset_q[h*HALF_W +: HALF_W] <= '0;
            end else if (wr[h]) begin
                offset_q[h*HALF_W +: HALF_W] <= din[h];
            end
        end
    end
endmodule

// File: rtl/vtime_read_mux.sv
module vtime_read_mux
    import vtime_pkg::*;
#(
    parameter bit RV32 = 1'b1,
    localparam int XLEN = RV32 ? 32 : 64
) (
    input  logic [TIME_W-1:0] time_i,
    input  logic [TIME_W-1:0] offset_q,
    input  logic              virt_en,
    input  dec_t              dec,
    output logic [XLEN-1:0]   rdata
);
    logic [TIME_W-1:0] guest_time;

    assign guest_time = time_i + (virt_en ? offset_q : '0);

    always_comb begin
        rdata = '0;
        if (!dec.illegal) begin
            unique case (dec.sel)
                REG_TIME:  rdata = guest_time[XLEN-1:0];
                REG_TIMEH: rdata = XLEN'(guest_time[TIME_W-1:HALF_W]);
                REG_OFS:   rdata = offset_q[XLEN-1:0];
                REG_OFSH:  rdata = XLEN'(offset_q[TIME_W-1:HALF_W]);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vtime_csr_unit.sv
module vtime_csr_unit
    import vtime_pkg::*;
#(
    parameter bit RV32 = 1'b1,
    localparam int XLEN = RV32 ? 32 : 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [63:0]     time_i,
    input  logic            time_src_present,
    input  logic            virt_en,
    input  logic [1:0]      priv,
    input  logic            csr_valid,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal
);
    dec_t              dec;
    logic [TIME_W-1:0] offset_q;
    logic [HALF_W-1:0] wd_lo;
    logic [HALF_W-1:0] wd_hi;

    if (RV32) begin : g_w32
        assign wd_lo = csr_wdata;
        assign wd_hi = csr_wdata;
    end else begin : g_w64
        assign wd_lo = csr_wdata[HALF_W-1:0];
        assign wd_hi = csr_wdata[TIME_W-1:HALF_W];
    end

    vtime_decode #(.RV32(RV32)) u_dec (
        .valid       (csr_valid),
        .we          (csr_we),
        .addr        (csr_addr),
        .priv        (priv),
        .virt_en     (virt_en),
        .src_present (time_src_present),
        .dec         (dec)
    );

    vtime_offset_reg u_ofs (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (dec.wr_lo),
        .wr_hi    (dec.wr_hi),
        .data_lo  (wd_lo),
        .data_hi  (wd_hi),
        .offset_q (offset_q)
    );

    vtime_read_mux #(.RV32(RV32)) u_mux (
        .time_i   (time_i),
        .offset_q (offset_q),
        .virt_en  (virt_en),
        .dec      (dec),
        .rdata    (csr_rdata)
    );

    assign csr_illegal = dec.illegal;
endmodule

// File: rtl/vtime_csr_chk.sv
module vtime_csr_chk
    import vtime_pkg::*;
#(
    parameter bit RV32 = 1'b1,
    localparam int XLEN = RV32 ? 32 : 64
) (
    input logic            clk,
    input logic            rst,
    input logic [63:0]     time_i,
    input logic            present,
    input logic            virt_en,
    input logic [1:0]      priv,
    input logic            valid,
    input logic            we,
    input logic [11:0]     addr,
    input logic [XLEN-1:0] rdata,
    input logic            illegal,
    input logic [63:0]     offset_q
);
    // R2
    nosrc_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !present) |-> illegal);

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && we && (addr == ADDR_TIME || addr == ADDR_TIMEH)) |-> illegal);

    // R8
    offset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid && we && !illegal) |=> $stable(offset_q));

    // R10
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (rdata == '0));

    // R1
    host_time_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !we && addr == ADDR_TIME && present && !virt_en)
        |-> (rdata == time_i[XLEN-1:0]));

    // R7
    user_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && priv == 2'd0 && (addr == ADDR_OFS || addr == ADDR_OFSH))
        |-> illegal);
endmodule

bind vtime_csr_unit vtime_csr_chk #(.RV32(RV32)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .time_i   (time_i),
    .present  (time_src_present),
    .virt_en  (virt_en),
    .priv     (priv),
    .valid    (csr_valid),
    .we       (csr_we),
    .addr     (csr_addr),
    .rdata    (csr_rdata),
    .illegal  (csr_illegal),
    .offset_q (offset_q)
);

// File: tb/tb_vtime_csr_unit.sv
`timescale 1ns/1ps
module tb_vtime_csr_unit;
    import vtime_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_i = '0;
    logic        present = 1'b1;
    logic        virt = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        valid = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [31:0] rd32;
    logic        ill32;
    logic [63:0] rd64;
    logic        ill64;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vtime_csr_unit #(.RV32(1'b1)) dut (
        .clk(clk), .rst(rst), .time_i(time_i), .time_src_present(present),
        .virt_en(virt), .priv(priv), .csr_valid(valid), .csr_we(we),
        .csr_addr(addr), .csr_wdata(wdata[31:0]), .csr_rdata(rd32),
        .csr_illegal(ill32)
    );

    vtime_csr_unit #(.RV32(1'b0)) dut_w64 (
        .clk(clk), .rst(rst), .time_i(time_i), .time_src_present(present),
        .virt_en(virt), .priv(priv), .csr_valid(valid), .csr_we(we),
        .csr_addr(addr), .csr_wdata(wdata), .csr_rdata(rd64),
        .csr_illegal(ill64)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: driven at negedge, sampled 1 ns later, write lands at next posedge.
    task automatic access(input logic [11:0] a, input logic w, input logic [63:0] d,
                          output logic [31:0] r32, output logic i32,
                          output logic [63:0] r64, output logic i64);
        @(negedge clk);
        valid = 1'b1; we = w; addr = a; wdata = d;
        #1;
        r32 = rd32; i32 = ill32; r64 = rd64; i64 = ill64;
        @(negedge clk);
        valid = 1'b0; we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; present = 1'b1; virt = 1'b0; priv = 2'd3; valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r32; logic i32; logic [63:0] r64; logic i64;
        do_reset();
        time_i = 64'h0000_0000_0000_1234;
        virt = 1'b1;
        access(ADDR_TIME, 1'b0, '0, r32, i32, r64, i64);
        check("R10 time after reset", {32'h0, r32}, 64'h1234);
        check("R10 same-cycle legal", {63'h0, i32}, 64'h0);
        virt = 1'b0;
        access(ADDR_OFSH, 1'b0, '0, r32, i32, r64, i64);
        check("R10 offset high reset", {32'h0, r32}, 64'h0);
        access(ADDR_OFS, 1'b0, '0, r32, i32, r64, i64);
        check("R10 offset 64 reset", r64, 64'h0);
    endtask

    task automatic t_halves();
        logic [31:0] r32; logic i32; logic [63:0] r64; logic i64;
        do_reset();
        access(ADDR_OFS, 1'b1, 64'h0000_0000_AAAA_5555, r32, i32, r64, i64);
        access(ADDR_OFSH, 1'b1, 64'h0000_0000_1234_5678, r32, i32, r64, i64);
        access(ADDR_OFS, 1'b0, '0, r32, i32, r64, i64);
        check("R5 low half read", {32'h0, r32}, 64'hAAAA_5555);
        access(ADDR_OFSH, 1'b0, '0, r32, i32, r64, i64);
        check("R5 high half read", {32'h0, r32}, 64'h1234_5678);
        access(ADDR_OFS, 1'b1, 64'h0000_0000_0000_0001, r32, i32, r64, i64);
        access(ADDR_OFSH, 1'b0, '0, r32, i32, r64, i64);
        check("R4 low write keeps high", {32'h0, r32}, 64'h1234_5678);
        access(ADDR_OFS, 1'b0, '0, r32, i32, r64, i64);
        check("R4 low write replaced", {32'h0, r32}, 64'h1);
    endtask

    task automatic t_carry();
        logic [31:0] r32; logic i32; logic [63:0] r64; logic i64;
        do_reset();
        access(ADDR_OFS, 1'b1, 64'h20, r32, i32, r64, i64);
        time_i = 64'h0000_0001_FFFF_FFF0;
        virt = 1'b1;
        access(ADDR_TIMEH, 1'b0, '0, r32, i32, r64, i64);
        check("R3 timeh carries", {32'h0, r32}, 64'h2);
        access(ADDR_TIME, 1'b0, '0, r32, i32, r64, i64);
        check("R1 guest time low", {32'h0, r32}, 64'h10);
        virt = 1'b0;
        access(ADDR_TIME, 1'b0, '0, r32, i32, r64, i64);
        check("R1 host time low", {32'h0, r32}, 64'hFFFF_FFF0);
        access(ADDR_TIMEH, 1'b0, '0, r32, i32, r64, i64);
        check("R3 host timeh", {32'h0, r32}, 64'h1);
    endtask

    task automatic t_w64();
        logic [31:0] r32; logic i32; logic [63:0] r64; logic i64;
        do_reset();
        access(ADDR_OFS, 1'b1, 64'h8000_0000_0000_0010, r32, i32, r64, i64);
        access(ADDR_OFS, 1'b0, '0, r32, i32, r64, i64);
        check("R6 full offset read", r64, 64'h8000_0000_0000_0010);
        time_i = 64'h7FFF_FFFF_FFFF_FFF8;
        virt = 1'b1;
        access(ADDR_TIME, 1'b0, '0, r32, i32, r64, i64);
        check("R9 wrap sum", r64, 64'h0000_0000_0000_0008);
        access(ADDR_TIMEH, 1'b0, '0, r32, i32, r64, i64);
        check("R6 timeh absent", {63'h0, i64}, 64'h1);
        virt = 1'b0;
        access(ADDR_OFSH, 1'b0, '0, r32, i32, r64, i64);
        check("R6 offset-high absent", {63'h0, i64}, 64'h1);
    endtask

    task automatic t_nosrc();
        logic [31:0] r32; logic i32; logic [63:0] r64; logic i64;
        do_reset();
        access(ADDR_OFS, 1'b1, 64'h55, r32, i32, r64, i64);
        present = 1'b0;
        time_i = 64'h99;
        access(ADDR_TIME, 1'b0, '0, r32, i32, r64, i64);
        check("R2 time refused", {63'h0, i32}, 64'h1);
        check("R10 refused data zero", {32'h0, r32}, 64'h0);
        access(ADDR_TIMEH, 1'b0, '0, r32, i32, r64, i64);
        check("R2 timeh refused", {63'h0, i32}, 64'h1);
        access(ADDR_OFSH, 1'b0, '0, r32, i32, r64, i64);
        check("R2 offset-high refused", {63'h0, i32}, 64'h1);
        access(ADDR_OFS, 1'b1, 64'hFF, r32, i32, r64, i64);
        check("R2 offset write refused", {63'h0, i64}, 64'h1);
        present = 1'b1;
        access(ADDR_OFS, 1'b0, '0, r32, i32, r64, i64);
        check("R2 offset unchanged", r64, 64'h55);
    endtask

    task automatic t_priv();
        logic [31:0] r32; logic i32; logic [63:0] r64; logic i64;
        do_reset();
        access(ADDR_OFS, 1'b1, 64'h7, r32, i32, r64, i64);
        priv = 2'd0;
        time_i = 64'h42;
        access(ADDR_TIME, 1'b0, '0, r32, i32, r64, i64);
        check("R7 user reads time", {31'h0, i32, r32}, 64'h42);
        access(ADDR_OFS, 1'b1, 64'h9, r32, i32, r64, i64);
        check("R7 user offset write refused", {63'h0, i32}, 64'h1);
        priv = 2'd1; virt = 1'b1;
        access(ADDR_OFS, 1'b0, '0, r32, i32, r64, i64);
        check("R7 guest offset refused", {63'h0, i64}, 64'h1);
        virt = 1'b0;
        access(ADDR_OFS, 1'b0, '0, r32, i32, r64, i64);
        check("R7 supervisor offset read", {63'h0, i64} | r64, 64'h7);
    endtask

    task automatic t_readonly();
        logic [31:0] r32; logic i32; logic [63:0] r64; logic i64;
        do_reset();
        access(ADDR_OFS, 1'b1, 64'h3, r32, i32, r64, i64);
        access(ADDR_TIME, 1'b1, 64'hDEAD, r32, i32, r64, i64);
        check("R8 time write refused", {63'h0, i32}, 64'h1);
        access(ADDR_TIMEH, 1'b1, 64'hBEEF, r32, i32, r64, i64);
        check("R8 timeh write refused", {63'h0, i32}, 64'h1);
        time_i = 64'h100; virt = 1'b1;
        access(ADDR_TIME, 1'b0, '0, r32, i32, r64, i64);
        check("R8 no state change", {32'h0, r32}, 64'h103);
    endtask

    initial begin
        t_reset();
        t_halves();
        t_carry();
        t_w64();
        t_nosrc();
        t_priv();
        t_readonly();
        done = 1'b1;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
    end

    initial begin
        wait (done || $time > 99000);
        #10;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule